// File: doc/BRIEF.md
# Prescaled Timebase with Coherent Pair Capture

This block is a free-running timebase built from two 32-bit counters. A prescale counter advances on every clock while the global enable is high. Each time it matches a programmable limit, it returns to zero and advances a second, free-running counter by one. An external strobe makes a snapshot of both counters in the same clock edge.

Software sees the block through a single-cycle register port. Read data is valid in the same cycle as the request, and writes carry a privilege flag. Reading a whole pair through a 32-bit port is made coherent by a fixed order. The free-running register (live or captured) is read first, and that read stores its matching prescale value in a shadow. A later read of the prescale register (live or captured) returns that shadow, even if the counters moved or a new snapshot was taken in between.

Top module: `tbase_pair`

## Requirements
- R1: After a synchronous reset, both counters, both snapshot registers and both shadows are zero, and the limit register holds the parameter CMP_INIT (default 0).
- R2: While cnt_en is high, a prescale value different from the limit increments by one per clock. A prescale value equal to the limit returns to zero in the next clock, and in that clock the free-running counter increments by one. After n enabled clocks from zero with limit c, the free-running counter is n/(c+1) and the prescale counter is n mod (c+1).
- R3: While cnt_en is low and no privileged write occurs, neither counter changes.
- R4: The free-running counter wraps from FFFF_FFFFh to zero and does not saturate.
- R5: A read at address 0 returns the live free-running value of that cycle and copies the live prescale value into the live shadow. A read at address 1 returns the live shadow and not the live prescale value.
- R6: A privileged write at address 0 presets the free-running counter, and counting then continues upward from the written value.
- R7: A privileged write at address 1 presets the prescale counter. Address 2 is the limit register; a privileged write sets it and a read returns it.
- R8: A write with acc_priv low changes no register.
- R9: On a clock with cap_evt high, the prescale and free-running values present before that edge are stored in the snapshot registers together.
- R10: A read at address 3 returns the free-running snapshot and copies the prescale snapshot into the snapshot shadow. A read at address 4 returns that shadow, so a snapshot taken between the two reads does not change it.
- R11: The snapshot registers at addresses 3 and 4 are read-only; a privileged write there has no effect.
- R12: Reads at addresses 5 to 7 return zero, and acc_rdata is zero whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Global counting enable |
| cap_evt | input | 1 | Snapshot strobe |
| acc_en | input | 1 | Register access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Access is privileged |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the request cycle |

## Verification
The assertions assume that any privileged write might alter a counter, so they make no claim about counter steps in a clock with such a write. They also assume that a matching limit is reached by equality, which holds only when the prescale counter was not preset above the limit. The stimulus performs all presets with cnt_en low and always presets the prescale counter below the limit. Snapshot strobes are single-clock pulses. The pair sweep covers limits 0 to 4 and run lengths 1 to 13, and compares each pair with the quotient and remainder computed in the bench.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_FR_LIVE = 3'd0,
        RA_UP_LIVE = 3'd1,
        RA_LIMIT   = 3'd2,
        RA_FR_SNAP = 3'd3,
        RA_UP_SNAP = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              en;
        logic              wr;
        logic              priv;
        logic [ADDR_W-1:0] addr;
    } acc_ctl_t;

    function automatic logic wr_hit(acc_ctl_t c, reg_addr_e r);
        return c.en && c.wr && c.priv && (c.addr == r);
    endfunction

    function automatic logic rd_hit(acc_ctl_t c, reg_addr_e r);
        return c.en && !c.wr && (c.addr == r);
    endfunction

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
    parameter int DW = 32,
    parameter logic [DW-1:0] CMP_INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          wr_up,
    input  logic          wr_lim,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] up_q,
    output logic [DW-1:0] lim_q,
    output logic          tick
);
    logic at_lim;

    assign at_lim = (up_q == lim_q);
    // a preset of the prescale counter overrides the roll-over in that clock
    assign tick   = cnt_en && at_lim && !wr_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= '0;
        end else if (wr_up) begin
            up_q <= wdata;
        end else if (cnt_en) begin
            up_q <= at_lim ? '0 : up_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= CMP_INIT;
        end else if (wr_lim) begin
            lim_q <= wdata;
        end
    end
endmodule

// File: rtl/tbase_freerun.sv
module tbase_freerun #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_fr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] fr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= '0;
        end else if (wr_fr) begin
            fr_q <= wdata;
        end else if (tick) begin
            fr_q <= fr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbase_capture.sv
module tbase_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_evt,
    input  logic [DW-1:0] up_q,
    input  logic [DW-1:0] fr_q,
    output logic [DW-1:0] cap_up_q,
    output logic [DW-1:0] cap_fr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_up_q <= '0;
            cap_fr_q <= '0;
        end else if (cap_evt) begin
            cap_up_q <= up_q;
            cap_fr_q <= fr_q;
        end
    end
endmodule

// File: rtl/tbase_regif.sv
module tbase_regif
    import tbase_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_ctl_t      ctl,
    input  logic [DW-1:0] up_q,
    input  logic [DW-1:0] fr_q,
    input  logic [DW-1:0] lim_q,
    input  logic [DW-1:0] cap_up_q,
    input  logic [DW-1:0] cap_fr_q,
    output logic          wr_fr,
    output logic          wr_up,
    output logic          wr_lim,
    output logic [DW-1:0] shd_live,
    output logic [DW-1:0] shd_cap,
    output logic [DW-1:0] rdata
);
    assign wr_fr  = wr_hit(ctl, RA_FR_LIVE);
    assign wr_up  = wr_hit(ctl, RA_UP_LIVE);
    assign wr_lim = wr_hit(ctl, RA_LIMIT);

    // shadows pair the prescale half with the free-running half just read
    always_ff @(posedge clk) begin
        if (rst) begin
            shd_live <= '0;
            shd_cap  <= '0;
        end else begin
            if (rd_hit(ctl, RA_FR_LIVE)) shd_live <= up_q;
            if (rd_hit(ctl, RA_FR_SNAP)) shd_cap  <= cap_up_q;
        end
    end

    always_comb begin
        rdata = '0;
        if (ctl.en && !ctl.wr) begin
            case (reg_addr_e'(ctl.addr))
                RA_FR_LIVE: rdata = fr_q;
                RA_UP_LIVE: rdata = shd_live;
                RA_LIMIT:   rdata = lim_q;
                RA_FR_SNAP: rdata = cap_fr_q;
                RA_UP_SNAP: rdata = shd_cap;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tbase_pair.sv
module tbase_pair
    import tbase_pkg::*;
#(
    parameter int DW = 32,
    parameter logic [DW-1:0] CMP_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              cap_evt,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_priv,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata
);
    acc_ctl_t      ctl;
    logic [DW-1:0] up_q, fr_q, lim_q, cap_up_q, cap_fr_q;
    logic [DW-1:0] shd_live, shd_cap;
    logic          tick, wr_fr, wr_up, wr_lim;

    assign ctl = '{en: acc_en, wr: acc_wr, priv: acc_priv, addr: acc_addr};

    tbase_prescale #(.DW(DW), .CMP_INIT(CMP_INIT)) u_pre (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_up(wr_up), .wr_lim(wr_lim),
        .wdata(acc_wdata), .up_q(up_q), .lim_q(lim_q), .tick(tick)
    );

    tbase_freerun #(.DW(DW)) u_fr (
        .clk(clk), .rst(rst), .tick(tick), .wr_fr(wr_fr),
        .wdata(acc_wdata), .fr_q(fr_q)
    );

    tbase_capture #(.DW(DW)) u_cap (
        .clk(clk), .rst(rst), .cap_evt(cap_evt), .up_q(up_q), .fr_q(fr_q),
        .cap_up_q(cap_up_q), .cap_fr_q(cap_fr_q)
    );

    tbase_regif #(.DW(DW)) u_rif (
        .clk(clk), .rst(rst), .ctl(ctl), .up_q(up_q), .fr_q(fr_q), .lim_q(lim_q),
        .cap_up_q(cap_up_q), .cap_fr_q(cap_fr_q), .wr_fr(wr_fr), .wr_up(wr_up),
        .wr_lim(wr_lim), .shd_live(shd_live), .shd_cap(shd_cap), .rdata(acc_rdata)
    );
endmodule

// File: rtl/tbase_pair_chk.sv
module tbase_pair_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cnt_en,
    input logic          cap_evt,
    input logic          acc_en,
    input logic          acc_wr,
    input logic          acc_priv,
    input logic [2:0]    acc_addr,
    input logic [DW-1:0] up_q,
    input logic [DW-1:0] fr_q,
    input logic [DW-1:0] lim_q,
    input logic [DW-1:0] cap_up_q,
    input logic [DW-1:0] cap_fr_q,
    input logic [DW-1:0] shd_live,
    input logic [DW-1:0] shd_cap
);
    logic pwr, uwr, rd_frl, rd_frs;
    assign pwr    = acc_en && acc_wr && acc_priv;
    assign uwr    = acc_en && acc_wr && !acc_priv;
    assign rd_frl = acc_en && !acc_wr && (acc_addr == 3'd0);
    assign rd_frs = acc_en && !acc_wr && (acc_addr == 3'd3);

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !pwr && (up_q != lim_q) |=> (up_q == $past(up_q) + 1'b1) && (fr_q == $past(fr_q)));

    assert_roll_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !pwr && (up_q == lim_q) |=> (up_q == '0) && (fr_q == $past(fr_q) + 1'b1));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_en && !pwr |=> $stable(up_q) && $stable(fr_q));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_en && !pwr && (up_q == lim_q) && (fr_q == '1) |=> fr_q == '0);

    assert_shadow_R5: assert property (@(posedge clk) disable iff (rst)
        rd_frl |=> shd_live == $past(up_q));

    assert_nopriv_R8: assert property (@(posedge clk) disable iff (rst)
        uwr |=> $stable(lim_q));

    assert_snap_R9: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap_up_q == $past(up_q)) && (cap_fr_q == $past(fr_q)));

    assert_snapshd_R10: assert property (@(posedge clk) disable iff (rst)
        rd_frs |=> shd_cap == $past(cap_up_q));

    assert_snapro_R11: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(cap_up_q) && $stable(cap_fr_q));
endmodule

bind tbase_pair tbase_pair_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_evt(cap_evt),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_priv(acc_priv), .acc_addr(acc_addr),
    .up_q(up_q), .fr_q(fr_q), .lim_q(lim_q), .cap_up_q(cap_up_q),
    .cap_fr_q(cap_fr_q), .shd_live(shd_live), .shd_cap(shd_cap)
);

// File: tb/tb_tbase_pair.sv
module tb_tbase_pair;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        cap_evt = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_priv = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] rd;

    // 8-unit period: 125 MHz with 1 ns units
    always #4 clk = ~clk;

    tbase_pair dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_evt(cap_evt),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_priv(acc_priv),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic en, input logic cap, input logic ae, input logic wr,
                       input logic pr, input logic [2:0] ad, input logic [31:0] wd,
                       output logic [31:0] r);
        @(negedge clk);
        cnt_en = en; cap_evt = cap; acc_en = ae; acc_wr = wr;
        acc_priv = pr; acc_addr = ad; acc_wdata = wd;
        #1 r = acc_rdata;
        @(posedge clk);
        #1;
        cap_evt = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_priv = 1'b0;
    endtask

    task automatic idle(input logic en, input int n);
        logic [31:0] d;
        for (int i = 0; i < n; i++) cyc(en, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0, d);
    endtask

    task automatic rdreg(input logic en, input logic [2:0] ad, output logic [31:0] r);
        cyc(en, 1'b0, 1'b1, 1'b0, 1'b0, ad, '0, r);
    endtask

    task automatic wrreg(input logic pr, input logic [2:0] ad, input logic [31:0] wd);
        logic [31:0] d;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, pr, ad, wd, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cnt_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1600000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state of every register
        do_reset();
        rdreg(0, 3'd0, rd); check("R1 fr", rd, 0);
        rdreg(0, 3'd1, rd); check("R1 up", rd, 0);
        rdreg(0, 3'd2, rd); check("R1 limit", rd, 0);
        rdreg(0, 3'd3, rd); check("R1 frsnap", rd, 0);
        rdreg(0, 3'd4, rd); check("R1 upsnap", rd, 0);
        // R12: unused addresses and idle port
        for (int a = 5; a < 8; a++) begin
            rdreg(0, 3'(a), rd); check("R12 unused", rd, 0);
        end
        #2 check("R12 idle", acc_rdata, 0);

        // R2 / R5: pair sweep over limits and run lengths
        for (int c = 0; c < 5; c++) begin
            for (int n = 1; n < 14; n++) begin
                do_reset();
                wrreg(1, 3'd2, 32'(c));
                idle(1, n);
                rdreg(1, 3'd0, rd); check("R2 fr pair", rd, 32'(n / (c + 1)));
                idle(1, 3);
                rdreg(1, 3'd1, rd); check("R5 up shadow", rd, 32'(n % (c + 1)));
            end
        end

        // R3: disabled counters hold
        do_reset();
        wrreg(1, 3'd2, 32'd2);
        idle(1, 7);
        idle(0, 5);
        rdreg(0, 3'd0, rd); check("R3 fr", rd, 32'd2);
        rdreg(0, 3'd1, rd); check("R3 up", rd, 32'd1);

        // R4: wrap of the free-running counter
        do_reset();
        wrreg(1, 3'd0, 32'hFFFF_FFFF);
        rdreg(0, 3'd0, rd); check("R6 preset", rd, 32'hFFFF_FFFF);
        idle(1, 2);
        rdreg(0, 3'd0, rd); check("R4 wrap", rd, 32'd1);

        // R6: count continues from preset
        do_reset();
        wrreg(1, 3'd2, 32'd1);
        wrreg(1, 3'd0, 32'h100);
        idle(1, 5);
        rdreg(0, 3'd0, rd); check("R6 fr", rd, 32'h102);
        rdreg(0, 3'd1, rd); check("R6 up", rd, 32'd1);

        // R7: prescale preset and limit register
        do_reset();
        wrreg(1, 3'd2, 32'd5);
        wrreg(1, 3'd1, 32'd2);
        rdreg(0, 3'd2, rd); check("R7 limit", rd, 32'd5);
        rdreg(0, 3'd0, rd); check("R7 fr", rd, 32'd0);
        rdreg(0, 3'd1, rd); check("R7 up preset", rd, 32'd2);
        idle(1, 4);
        rdreg(0, 3'd0, rd); check("R7 fr after", rd, 32'd1);
        rdreg(0, 3'd1, rd); check("R7 up after", rd, 32'd0);

        // R8: non-privileged writes ignored
        wrreg(0, 3'd0, 32'h55);
        wrreg(0, 3'd1, 32'h33);
        wrreg(0, 3'd2, 32'h9);
        rdreg(0, 3'd0, rd); check("R8 fr", rd, 32'd1);
        rdreg(0, 3'd1, rd); check("R8 up", rd, 32'd0);
        rdreg(0, 3'd2, rd); check("R8 limit", rd, 32'd5);

        // R9 / R10: snapshots and ordered read
        do_reset();
        wrreg(1, 3'd2, 32'd3);
        idle(1, 6);
        cyc(1, 1, 0, 0, 0, 3'd0, '0, rd);      // snapshot of 6 clocks: up 2, fr 1
        rdreg(0, 3'd4, rd); check("R10 shadow before", rd, 32'd0);
        idle(1, 5);
        rdreg(1, 3'd3, rd); check("R9 frsnap", rd, 32'd1);
        cyc(1, 1, 0, 0, 0, 3'd0, '0, rd);      // snapshot of 13 clocks: up 1, fr 3
        rdreg(1, 3'd4, rd); check("R10 paired up", rd, 32'd2);
        rdreg(0, 3'd3, rd); check("R9 frsnap new", rd, 32'd3);
        rdreg(0, 3'd4, rd); check("R9 upsnap new", rd, 32'd1);

        // R11: snapshot registers are read-only
        wrreg(1, 3'd3, 32'hDEAD);
        wrreg(1, 3'd4, 32'hBEEF);
        rdreg(0, 3'd3, rd); check("R11 frsnap", rd, 32'd3);
        rdreg(0, 3'd4, rd); check("R11 upsnap", rd, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule